// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a 32-bit effective address to a real address by walking a hashed page table in memory. It runs after a block-translation lookup has missed. Each request picks one of sixteen segment registers with the top address nibble. That register supplies a virtual segment identifier and two protection keys. The walker hashes the identifier with the page index to locate an eight-entry group, then reads entries through a 32-bit memory port until the first word of an entry equals a match word built from the request. If the primary group holds no match, the walker probes the secondary group, whose hash is the complement of the primary one.

On a match the walker fetches the entry's second word. It forms the real address, decodes read and write permission from the selected key and the entry's two protection bits, and reports a hit or a protection fault. Before it reports, it marks the entry as referenced and, for a granted write, as changed. Each mark is a single-byte write that is issued only when the flag was clear. The segment registers are loaded through their own write port. Memory reads return data on the cycle after the request.

Top module: `hpt_walker`

## Requirements
- R1: The segment register is selected by `req_ea[31:28]` and is loaded through `seg_we`/`seg_idx`/`seg_wdata`. Its fields are: bits 27:0 the segment identifier, bit 29 the key used in user mode, bit 30 the key used in supervisor mode. If bit 31 is set, the walk ends with `miss` and makes no memory access.
- R2: The primary hash is (segment identifier XOR `req_ea[27:12]`) shifted left by 6. The group address is `{tbl_cfg[31:16],16'h0}` ORed with the hash ANDed with the mask `{7'b0, tbl_cfg[8:0], 16'hFFC0}`.
- R3: The secondary probe uses the bitwise complement of the unmasked primary hash. It starts only after all 8 primary entries fail to match. Its match word has bit 6 set, and the primary match word has bit 6 clear.
- R4: The match word is bit 31 set, ORed with the segment identifier shifted left by 7 (kept to 32 bits), ORed with the probe bit 6, ORed with `req_ea[27:22]` in bits 5:0. Entry k has its first word at group+8k and its second word at group+8k+4. Entries are scanned from k=0 upward, and the lowest matching entry wins.
- R5: `real_addr` is the second word's bits 31:12 joined with `req_ea[11:0]`.
- R6: The key is the user key when `req_user` is high and the supervisor key otherwise. pp is second-word bits 1:0. With key 0, pp 0, 1 and 2 grant read/write and pp 3 grants read only. With key 1, pp 0 grants nothing, pp 2 grants read/write, and pp 1 and pp 3 grant read only.
- R7: `done` pulses for one cycle with exactly one of `hit`, `miss`, `prot_fault`. `prot_fault` is raised when a matched entry denies read, or denies write on a write access. `perm_x` is high for every matched entry.
- R8: The referenced flag is second-word bit 8. When read is granted and the flag is clear, it is set by one write with `mem_be=4'b0010` (byte lanes: `mem_be[k]` covers bits 8k+7:8k, and words are big-endian, so lane 3 is the lowest byte address). No write is made when the flag is already set.
- R9: The changed flag is second-word bit 7. It is set by one write with `mem_be=4'b0001`, only on a write access that is granted and only when the flag is clear.
- R10: After reset, `busy`, `done` and `mem_req` are low. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_we | input | 1 | Segment register write enable |
| seg_idx | input | 4 | Segment register to write |
| seg_wdata | input | 32 | Segment register write value |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | Access is a store |
| req_user | input | 1 | Access is made in user mode |
| tbl_cfg | input | 32 | Table base (31:16) and size field (8:0) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Translation granted |
| miss | output | 1 | No usable entry or segment |
| prot_fault | output | 1 | Entry matched but access denied |
| real_addr | output | 32 | Translated address |
| perm_r | output | 1 | Entry grants read |
| perm_w | output | 1 | Entry grants write |
| perm_x | output | 1 | Entry grants execute |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of word |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
On every cycle, the assertions check the result encoding at `done`, the byte-lane shape and flag content of each table write, the page-offset pass-through, the ordering of the secondary probe after the last primary entry, and the quiet exit on an unusable segment. Three behaviours show only in the bench's scenarios, which compare memory contents and access counts against a bench-side table model: which entry wins when several match, that a matching word planted in the wrong group is ignored, and that each flag write happens only when the flag was clear.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_CMP, ST_RD1, ST_CHK, ST_WRR, ST_WRC, ST_END
  } walk_st_t;

  localparam int REF_BIT = 8;
  localparam int CHG_BIT = 7;

  // Unmasked probe hash; the secondary probe takes its complement.
  function automatic logic [31:0] probe_hash(input logic [27:0] vsid,
                                             input logic [15:0] page,
                                             input logic        sec);
    logic [31:0] h;
    h = {4'b0, vsid ^ {12'b0, page}} << 6;
    return sec ? ~h : h;
  endfunction

  function automatic logic [31:0] group_base(input logic [15:0] base,
                                             input logic [8:0]  size,
                                             input logic [31:0] hash);
    logic [31:0] mask;
    mask = {7'b0, size, 16'hFFC0};
    return {base, 16'h0000} | (hash & mask);
  endfunction

  function automatic logic [31:0] match_word(input logic [24:0] vsid_lo,
                                             input logic [5:0]  api,
                                             input logic        sec);
    return 32'h8000_0000 | {vsid_lo, 7'b0} | {25'b0, sec, api};
  endfunction

  // Returns {read, write}.
  function automatic logic [1:0] perm_decode(input logic key, input logic [1:0] pp);
    logic [1:0] rw;
    if (!key) rw = (pp == 2'd3) ? 2'b10 : 2'b11;
    else begin
      case (pp)
        2'd0:    rw = 2'b00;
        2'd2:    rw = 2'b11;
        default: rw = 2'b10;
      endcase
    end
    return rw;
  endfunction

endpackage

// File: rtl/hpt_segfile.sv
module hpt_segfile #(
  parameter int SEG_CNT  = 16,
  parameter int SEG_BITS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(SEG_CNT)-1:0] wr_idx,
  input  logic [SEG_BITS-1:0]        wr_val,
  input  logic [$clog2(SEG_CNT)-1:0] rd_idx,
  output logic [SEG_BITS-1:0]        rd_val
);
  localparam int IDX_W = $clog2(SEG_CNT);

  logic [SEG_BITS-1:0] seg_all [SEG_CNT];

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
    logic [SEG_BITS-1:0] seg_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                seg_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))     seg_q <= wr_val;
    end
    assign seg_all[g] = seg_q;
  end

  assign rd_val = seg_all[rd_idx];

endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen import hpt_pkg::*; #(
  parameter int SLOTS = 8
) (
  input  logic [15:0]              tbl_base,
  input  logic [8:0]               tbl_size,
  input  logic [27:0]              vsid,
  input  logic [15:0]              page,
  input  logic                     sec,
  input  logic [$clog2(SLOTS)-1:0] slot,
  input  logic                     word_sel,
  output logic [31:0]              addr
);
  localparam int ENTRY_SHIFT = 3;

  logic [31:0] grp_addr;

  assign grp_addr = group_base(tbl_base, tbl_size, probe_hash(vsid, page, sec));
  assign addr     = grp_addr | (32'(slot) << ENTRY_SHIFT) | {29'b0, word_sel, 2'b00};

endmodule

// File: rtl/hpt_perm.sv
module hpt_perm import hpt_pkg::*; (
  input  logic       user_mode,
  input  logic       key_user,
  input  logic       key_sup,
  input  logic       is_write,
  input  logic [1:0] pp,
  input  logic       ref_seen,
  input  logic       chg_seen,
  output logic       may_rd,
  output logic       may_wr,
  output logic       deny,
  output logic       set_ref,
  output logic       set_chg
);
  logic       key;
  logic [1:0] rw;

  assign key     = user_mode ? key_user : key_sup;
  assign rw      = perm_decode(key, pp);
  assign may_rd  = rw[1];
  assign may_wr  = rw[0];
  assign deny    = !may_rd || (is_write && !may_wr);
  assign set_ref = may_rd && !ref_seen;
  assign set_chg = is_write && may_wr && !chg_seen;

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker import hpt_pkg::*; #(
  parameter int SEG_CNT = 16,
  parameter int SLOTS   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seg_we,
  input  logic [3:0]  seg_idx,
  input  logic [31:0] seg_wdata,
  input  logic        req_valid,
  input  logic [31:0] req_ea,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31:0] tbl_cfg,
  output logic        busy,
  output logic        done,
  output logic        hit,
  output logic        miss,
  output logic        prot_fault,
  output logic [31:0] real_addr,
  output logic        perm_r,
  output logic        perm_w,
  output logic        perm_x,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int SEG_W = $clog2(SEG_CNT);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  walk_st_t          st_q;
  logic [27:0]       ea_q;
  logic              wr_q, user_q, ks_q, kp_q, sec_q, need_c_q;
  logic [27:0]       vsid_q;
  logic [15:0]       tbase_q;
  logic [8:0]        tsize_q;
  logic [SLOT_W-1:0] slot_q;
  logic [31:0]       w1_q, real_addr_q;
  logic              hit_q, miss_q, fault_q, pr_q, pw_q, px_q;

  // Segment registers
  logic [31:0] seg_rd;
  logic        unused_seg_bit;
  logic [6:0]  unused_cfg_bits;
  assign unused_seg_bit  = seg_rd[28];
  assign unused_cfg_bits = tbl_cfg[15:9];

  hpt_segfile #(.SEG_CNT(SEG_CNT), .SEG_BITS(32)) u_segs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (seg_we),
    .wr_idx (seg_idx[SEG_W-1:0]),
    .wr_val (seg_wdata),
    .rd_idx (req_ea[31 -: SEG_W]),
    .rd_val (seg_rd)
  );

  // Named events for the checks
  logic [31:0] mword;
  logic        accept, entry_match, group_done, bad_seg;
  assign mword       = match_word(vsid_q[24:0], ea_q[27:22], sec_q);
  assign accept      = req_valid && (st_q == ST_IDLE);
  assign bad_seg     = seg_rd[31];
  assign entry_match = (st_q == ST_CMP) && (mem_rdata == mword);
  assign group_done  = (st_q == ST_CMP) && !entry_match && (slot_q == LAST_SLOT);

  // Address generation
  logic word_sel;
  assign word_sel = (st_q == ST_RD1) || (st_q == ST_WRR) || (st_q == ST_WRC);

  hpt_addr_gen #(.SLOTS(SLOTS)) u_addr (
    .tbl_base (tbase_q),
    .tbl_size (tsize_q),
    .vsid     (vsid_q),
    .page     (ea_q[27:12]),
    .sec      (sec_q),
    .slot     (slot_q),
    .word_sel (word_sel),
    .addr     (mem_addr)
  );

  // Permission decode on the second word as it arrives
  logic may_rd, may_wr, deny, set_ref, set_chg;
  hpt_perm u_perm (
    .user_mode (user_q),
    .key_user  (kp_q),
    .key_sup   (ks_q),
    .is_write  (wr_q),
    .pp        (mem_rdata[1:0]),
    .ref_seen  (mem_rdata[REF_BIT]),
    .chg_seen  (mem_rdata[CHG_BIT]),
    .may_rd    (may_rd),
    .may_wr    (may_wr),
    .deny      (deny),
    .set_ref   (set_ref),
    .set_chg   (set_chg)
  );

  logic [31:0] w1_next;
  always_comb begin
    w1_next = mem_rdata;
    if (set_ref) w1_next[REF_BIT] = 1'b1;
    if (set_chg) w1_next[CHG_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ea_q <= '0; wr_q <= 1'b0; user_q <= 1'b0; ks_q <= 1'b0; kp_q <= 1'b0;
      vsid_q <= '0; tbase_q <= '0; tsize_q <= '0; sec_q <= 1'b0; slot_q <= '0;
      need_c_q <= 1'b0; w1_q <= '0; real_addr_q <= '0;
      hit_q <= 1'b0; miss_q <= 1'b0; fault_q <= 1'b0;
      pr_q <= 1'b0; pw_q <= 1'b0; px_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          ea_q    <= req_ea[27:0];
          wr_q    <= req_write;
          user_q  <= req_user;
          vsid_q  <= seg_rd[27:0];
          ks_q    <= seg_rd[30];
          kp_q    <= seg_rd[29];
          tbase_q <= tbl_cfg[31:16];
          tsize_q <= tbl_cfg[8:0];
          sec_q   <= 1'b0;
          slot_q  <= '0;
          hit_q <= 1'b0; fault_q <= 1'b0; real_addr_q <= '0;
          pr_q <= 1'b0; pw_q <= 1'b0; px_q <= 1'b0;
          miss_q  <= bad_seg;
          st_q    <= bad_seg ? ST_END : ST_RD0;
        end
        ST_RD0: st_q <= ST_CMP;
        ST_CMP: begin
          if (entry_match) st_q <= ST_RD1;
          else if (group_done) begin
            if (sec_q) begin
              miss_q <= 1'b1;
              st_q   <= ST_END;
            end else begin
              sec_q  <= 1'b1;
              slot_q <= '0;
              st_q   <= ST_RD0;
            end
          end else begin
            slot_q <= slot_q + 1'b1;
            st_q   <= ST_RD0;
          end
        end
        ST_RD1: st_q <= ST_CHK;
        ST_CHK: begin
          w1_q        <= w1_next;
          real_addr_q <= {mem_rdata[31:12], ea_q[11:0]};
          pr_q        <= may_rd;
          pw_q        <= may_wr;
          px_q        <= 1'b1;
          hit_q       <= !deny;
          fault_q     <= deny;
          need_c_q    <= set_chg;
          st_q        <= set_ref ? ST_WRR : (set_chg ? ST_WRC : ST_END);
        end
        ST_WRR:  st_q <= need_c_q ? ST_WRC : ST_END;
        ST_WRC:  st_q <= ST_END;
        ST_END:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_END);
  assign hit        = hit_q;
  assign miss       = miss_q;
  assign prot_fault = fault_q;
  assign real_addr  = real_addr_q;
  assign perm_r     = pr_q;
  assign perm_w     = pw_q;
  assign perm_x     = px_q;
  assign mem_req    = (st_q == ST_RD0) || (st_q == ST_RD1) || (st_q == ST_WRR) || (st_q == ST_WRC);
  assign mem_we     = (st_q == ST_WRR) || (st_q == ST_WRC);
  assign mem_be     = (st_q == ST_WRR) ? 4'b0010 : ((st_q == ST_WRC) ? 4'b0001 : 4'b1111);
  assign mem_wdata  = w1_q;

  // R7
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({hit, miss, prot_fault}) == 1);
  // R7
  exec_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !miss) |-> perm_x);
  // R8
  ref_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be == 4'b0010) |-> mem_wdata[REF_BIT]);
  // R9
  chg_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be == 4'b0001) |-> (mem_wdata[CHG_BIT] && wr_q));
  // R8
  byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $countones(mem_be) == 1);
  // R5
  page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !miss) |-> real_addr[11:0] == ea_q[11:0]);
  // R3
  sec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_q) |-> $past(group_done));
  // R1
  bad_seg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_seg) |=> (done && miss && !mem_req));
  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

endmodule

// File: tb/hpt_walker_test.sv
module hpt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_we = 1'b0;
  logic [3:0]  seg_idx = '0;
  logic [31:0] seg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] tbl_cfg = '0;
  logic        busy, done, hit, miss, prot_fault, perm_r, perm_w, perm_x;
  logic [31:0] real_addr, mem_addr, mem_wdata;
  logic        mem_req, mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  hpt_walker uut (
    .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_idx(seg_idx), .seg_wdata(seg_wdata),
    .req_valid(req_valid), .req_ea(req_ea), .req_write(req_write), .req_user(req_user),
    .tbl_cfg(tbl_cfg), .busy(busy), .done(done), .hit(hit), .miss(miss),
    .prot_fault(prot_fault), .real_addr(real_addr), .perm_r(perm_r), .perm_w(perm_w),
    .perm_x(perm_x), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Table memory: 16 KiB window, lane k = bits 8k+7:8k
  logic [31:0] mem [0:4095];
  int rd_cnt = 0;
  int wr_cnt = 0;
  always @(posedge clk) begin
    if (mem_req && !mem_we) begin
      mem_rdata <= mem[mem_addr[13:2]];
      rd_cnt++;
    end
    if (mem_req && mem_we) begin
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) mem[mem_addr[13:2]][8*k +: 8] = mem_wdata[8*k +: 8];
      wr_cnt++;
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] segm [16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench-side table arithmetic
  function automatic logic [31:0] b_group(input logic [31:0] tb, input logic [27:0] vsid,
                                          input logic [15:0] page, input bit sec);
    logic [31:0] h, m;
    h = (32'(vsid) ^ 32'(page)) * 64;
    if (sec) h = 32'hFFFF_FFFF - h;
    m = 32'(tb[8:0]) * 65536 + 32'h0000_FFC0;
    return (tb & 32'hFFFF_0000) | (h & m);
  endfunction

  function automatic logic [31:0] b_match(input logic [27:0] vsid, input logic [31:0] ea, input bit sec);
    logic [31:0] v;
    v = 32'(vsid) * 128;
    return v | 32'h8000_0000 | (sec ? 32'h40 : 32'h0) | ((ea >> 22) & 32'h3F);
  endfunction

  int          exp_code, exp_nw;
  logic [31:0] exp_pa, exp_w1;
  logic [11:0] exp_idx;
  bit          exp_found, exp_r, exp_w;

  task automatic ref_walk(input logic [31:0] ea, input bit wr, input bit us,
                          input logic [31:0] sg, input logic [31:0] tb);
    logic [31:0] a, w1;
    bit key;
    exp_code = 1; exp_nw = 0; exp_pa = 0; exp_w1 = 0; exp_idx = 0;
    exp_found = 0; exp_r = 0; exp_w = 0;
    if (!sg[31]) begin
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 8; k++) begin
          a = b_group(tb, sg[27:0], ea[27:12], s[0]) + 32'(8 * k);
          if (!exp_found && mem[a[13:2]] == b_match(sg[27:0], ea, s[0])) begin
            exp_found = 1;
            a = a + 4;
            exp_idx = a[13:2];
          end
        end
    end
    if (exp_found) begin
      w1 = mem[exp_idx];
      key = us ? sg[29] : sg[30];
      case ({key, w1[1:0]})
        3'b000, 3'b001, 3'b010, 3'b110: begin exp_r = 1; exp_w = 1; end
        3'b100:                         begin exp_r = 0; exp_w = 0; end
        default:                        begin exp_r = 1; exp_w = 0; end
      endcase
      exp_pa = {w1[31:12], ea[11:0]};
      exp_code = (!exp_r || (wr && !exp_w)) ? 2 : 0;
      if (exp_r && !w1[8]) begin w1[8] = 1'b1; exp_nw++; end
      if (wr && exp_w && !w1[7]) begin w1[7] = 1'b1; exp_nw++; end
      exp_w1 = w1;
    end
  endtask

  task automatic wr_seg(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    seg_we = 1'b1; seg_idx = idx; seg_wdata = val;
    @(negedge clk);
    seg_we = 1'b0;
    segm[idx] = val;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
  endtask

  function automatic int code_now();
    return hit ? 0 : (miss ? 1 : (prot_fault ? 2 : 3));
  endfunction

  task automatic do_walk(input logic [31:0] ea, input bit wr, input bit us,
                         input logic [31:0] tb, input string tag);
    int w0;
    ref_walk(ea, wr, us, segm[ea[31:28]], tb);
    w0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_write = wr; req_user = us; tbl_cfg = tb;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk({tag, " R7 result"}, 32'(code_now()), 32'(exp_code));
    if (exp_found) begin
      chk({tag, " R5 addr"}, real_addr, exp_pa);
      chk({tag, " R6 perms"}, {29'b0, perm_r, perm_w, perm_x}, {29'b0, exp_r, exp_w, 1'b1});
      @(negedge clk);
      chk({tag, " R8 flags"}, mem[exp_idx], exp_w1);
    end
    chk({tag, " R9 writes"}, 32'(wr_cnt - w0), 32'(exp_nw));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] tbd, sv5, ead, p0, s0, ea, tb, sv, rnd, a;
    int r0, mode, slot, s2, ds;
    bit wr, us;
    void'($urandom(32'd20240));
    for (int i = 0; i < 16; i++) segm[i] = 32'h0;
    clear_mem();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", {31'b0, busy}, 32'h0);
    chk("R10 done", {31'b0, done}, 32'h0);
    chk("R10 mem_req", {31'b0, mem_req}, 32'h0);
    rst_n = 1'b1;

    tbd = 32'h0012_0003;
    sv5 = 32'h20AB_CDEF;
    ead = 32'h5123_4567;
    wr_seg(4'd5, sv5);
    p0 = b_group(tbd, sv5[27:0], ead[27:12], 1'b0);
    s0 = b_group(tbd, sv5[27:0], ead[27:12], 1'b1);

    // R1 unusable segment: no memory access
    wr_seg(4'd6, 32'h8000_0001);
    r0 = rd_cnt;
    do_walk(32'h6000_0000, 1'b0, 1'b0, tbd, "R1");
    chk("R1 no reads", 32'(rd_cnt - r0), 32'h0);

    // R2 primary slot 0, supervisor read
    clear_mem();
    mem[p0[13:2]] = b_match(sv5[27:0], ead, 1'b0);
    a = p0 + 4; mem[a[13:2]] = 32'hABCD_E000;
    do_walk(ead, 1'b0, 1'b0, tbd, "R2");
    chk("R5 literal addr", real_addr, 32'hABCD_E567);
    chk("R8 literal flag", mem[a[13:2]], 32'hABCD_E100);

    // R4 lowest matching slot wins
    clear_mem();
    a = p0 + 16; mem[a[13:2]] = b_match(sv5[27:0], ead, 1'b0);
    a = p0 + 20; mem[a[13:2]] = 32'h1111_1002;
    a = p0 + 40; mem[a[13:2]] = b_match(sv5[27:0], ead, 1'b0);
    a = p0 + 44; mem[a[13:2]] = 32'h2222_2000;
    do_walk(ead, 1'b0, 1'b0, tbd, "R4");
    chk("R4 first slot", real_addr, 32'h1111_1567);

    // R3 secondary probe, with a secondary word parked in the primary group
    clear_mem();
    a = p0 + 8;  mem[a[13:2]] = b_match(sv5[27:0], ead, 1'b1);
    a = s0 + 32; mem[a[13:2]] = b_match(sv5[27:0], ead, 1'b1);
    a = s0 + 36; mem[a[13:2]] = 32'h3333_3001;
    r0 = rd_cnt;
    do_walk(ead, 1'b0, 1'b0, tbd, "R3");
    chk("R3 addr", real_addr, 32'h3333_3567);
    chk("R3 reads", 32'(rd_cnt - r0), 32'd14);

    // R6 user key set, pp 0: no access, no flag write
    clear_mem();
    mem[p0[13:2]] = b_match(sv5[27:0], ead, 1'b0);
    a = p0 + 4; mem[a[13:2]] = 32'h4444_4000;
    do_walk(ead, 1'b0, 1'b1, tbd, "R6");
    chk("R6 fault", {31'b0, prot_fault}, 32'h1);
    chk("R8 untouched", mem[a[13:2]], 32'h4444_4000);

    // R9 user key set, pp 2 write, referenced already set
    clear_mem();
    mem[p0[13:2]] = b_match(sv5[27:0], ead, 1'b0);
    a = p0 + 4; mem[a[13:2]] = 32'h4444_4102;
    do_walk(ead, 1'b1, 1'b1, tbd, "R9");
    chk("R9 changed set", mem[a[13:2]], 32'h4444_4182);

    // R7 supervisor key clear, pp 3 write: fault, referenced only
    clear_mem();
    mem[p0[13:2]] = b_match(sv5[27:0], ead, 1'b0);
    a = p0 + 4; mem[a[13:2]] = 32'h5555_5003;
    do_walk(ead, 1'b1, 1'b0, tbd, "R7");
    chk("R7 fault", {31'b0, prot_fault}, 32'h1);
    chk("R9 no changed", mem[a[13:2]], 32'h5555_5103);

    // R10 request during a walk is ignored
    clear_mem();
    a = s0 + 8; mem[a[13:2]] = b_match(sv5[27:0], ead, 1'b1);
    a = s0 + 12; mem[a[13:2]] = 32'h6666_6100;
    ref_walk(ead, 1'b0, 1'b0, sv5, tbd);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ead; req_write = 1'b0; req_user = 1'b0; tbl_cfg = tbd;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_ea = 32'h6000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R10 first result", real_addr, 32'h6666_6567);
    chk("R10 code", 32'(code_now()), 32'h0);
    @(negedge clk); @(negedge clk);
    chk("R10 idle after", {31'b0, busy}, 32'h0);

    // Random walks
    for (int it = 0; it < 200; it++) begin
      clear_mem();
      sv = $urandom;
      sv[31] = ($urandom % 10 == 0);
      rnd = $urandom;
      ea = {rnd[31:28], 28'($urandom)};
      wr_seg(ea[31:28], sv);
      tb = $urandom;
      wr = 1'($urandom);
      us = 1'($urandom);
      mode = $urandom % 4;
      slot = $urandom % 8;
      s2 = $urandom % 8;
      ds = $urandom % 8;
      p0 = b_group(tb, sv[27:0], ea[27:12], 1'b0);
      s0 = b_group(tb, sv[27:0], ea[27:12], 1'b1);
      if (mode == 1 || mode == 3) begin
        a = p0 + 32'(8 * slot); mem[a[13:2]] = b_match(sv[27:0], ea, 1'b0);
        a = a + 4;              mem[a[13:2]] = $urandom;
      end
      if (mode == 2 || mode == 3) begin
        a = s0 + 32'(8 * s2); mem[a[13:2]] = b_match(sv[27:0], ea, 1'b1);
        a = a + 4;            mem[a[13:2]] = $urandom;
      end
      if (ds != slot || mode == 0 || mode == 2) begin
        a = p0 + 32'(8 * ds); mem[a[13:2]] = b_match(sv[27:0], ea, 1'b1);
      end
      do_walk(ea, wr, us, tb, "R1 R2 R3 R4");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule